// File: doc/BRIEF.md
# Parallel Display Bus Host Controller

This block is the host-side master for an asynchronous, half-duplex parallel display bus of the 8080 style. The bus has no clock line. A system-side request port with valid/ready handshaking accepts four kinds of operation:

- write a command
- write data or a parameter
- read data
- read with the data/command line low

The block turns each accepted operation into one strobe cycle. It drives chip select, the data/command line and the write or read strobe. The low and high phases of the strobe each last a programmable number of system clocks.

The active bus width is chosen by a two-bit mode input and can be 8, 9, 16 or 18 lines. Lines outside the active width are forced to zero. Read data is captured on the clock edge where the read strobe rises. It is returned with a single-cycle done pulse.

A separate request pulses the panel reset output low for a programmable time. No bus access is accepted until the first such pulse has finished. A hold flag on a request keeps chip select asserted after the cycle, so that a command and its parameters can share one select window. The data bus is split into an output, an output enable and an input, and the pad ring joins them into the shared lines.

Top module: `dbus_master`

## Requirements
- R1: After system reset, chip select, write strobe and read strobe are high, output enable is low, the panel reset output is low and ready is low.
- R2: A panel reset request taken while idle drives the panel reset output low for max(N,1) clocks, where N is the reset count input, and then high. Ready stays low until that pulse has ended, and no request is accepted before the first pulse completes.
- R3: Operation codes are 00 write command, 01 write data, 10 read data and 11 read command. The data/command line is low for codes 00 and 11 and high for 01 and 10, from chip select fall to the end of the cycle.
- R4: In a cycle, the strobe matching the operation goes low for exactly max(L,1) clocks and then high for exactly max(H,1) clocks, where L and H are the low and high count inputs. The other strobe stays high, and the two strobes are never low together.
- R5: Chip select falls on the acceptance edge, one clock before the strobe falls. It rises (when hold is clear) one clock after the high phase, at the same time as done.
- R6: During a write, output enable is high from chip select fall until the end of the high phase. The data output equals the write data masked to the active width and does not change across the strobe rising edge.
- R7: Mode 00 selects 8 active lines, 01 selects 16, 10 selects 9 and 11 selects 18. Lines above the active width are zero on the data output and in returned read data.
- R8: During a read, output enable stays low for the whole cycle. The returned data equals the bus input present in the last clock before the read strobe rises, masked to the active width. Done is high for one clock with the error flag low.
- R9: A read with code 11 completes the strobe cycle with the data/command line low. It returns zero data with the error flag high.
- R10: A request with hold set leaves chip select low after its done pulse and through the idle clocks that follow. The next request without hold releases it at its own done.
- R11: Ready is high only when the bus is idle with both strobes high. Each handshake starts exactly one cycle, and done is high for a single clock per cycle.
- R12: Output enable changes only while both strobes are high, in both the clock before and the clock of the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| mode_i | input | 2 | Bus width select |
| lo_cyc_i | input | CNT_W | Strobe low-phase length in clocks (0 acts as 1) |
| hi_cyc_i | input | CNT_W | Strobe high-phase length in clocks (0 acts as 1) |
| rst_cyc_i | input | RST_W | Panel reset pulse length in clocks (0 acts as 1) |
| prst_req_i | input | 1 | Panel reset request |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_op_i | input | 2 | Operation code |
| req_hold_i | input | 1 | Keep chip select low after this cycle |
| req_wdata_i | input | 18 | Write data |
| rsp_done_o | output | 1 | One-clock completion pulse |
| rsp_err_o | output | 1 | Last read had data/command low |
| rsp_rdata_o | output | 18 | Captured read data |
| lcd_cs_n_o | output | 1 | Chip select, active low |
| lcd_dc_o | output | 1 | Data/command select, low for command |
| lcd_wr_n_o | output | 1 | Write strobe, active low |
| lcd_rd_n_o | output | 1 | Read strobe, active low |
| lcd_rst_n_o | output | 1 | Panel reset, active low |
| lcd_dq_o | output | 18 | Data bus output value |
| lcd_dq_oe_o | output | 1 | Data bus output enable |
| lcd_dq_i | input | 18 | Data bus input value |

## Verification
A table of operations steps through every operation code and every width mode. The strobe counts include zero, one and several clocks, so the phase rule of taking the larger of the count and one is told apart from off-by-one lengths. All-ones write data in the narrow modes shows whether the upper lines are masked. A panel model drives one value while the read strobe is low and its complement while it is high, which separates sampling before the rising edge from sampling after it. Directed runs cover the panel reset lengths before and after boot, and a held command followed by a parameter to test the select window.

// File: rtl/dbus_pkg.sv
package dbus_pkg;

    localparam int BUS_W = 18;

    typedef enum logic [1:0] {
        OP_WR_CMD = 2'b00,
        OP_WR_DAT = 2'b01,
        OP_RD_DAT = 2'b10,
        OP_RD_CMD = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_LOW   = 2'd2,
        ST_HIGH  = 2'd3
    } bus_st_e;

    localparam int W_MODE0 = 8;
    localparam int W_MODE1 = 16;
    localparam int W_MODE2 = 9;
    localparam int W_MODE3 = 18;

endpackage

// File: rtl/dbus_lane_mask.sv
module dbus_lane_mask
    import dbus_pkg::*;
(
    input  logic [1:0]       mode_i,
    output logic [BUS_W-1:0] mask_o
);
    int unsigned width;

    always_comb begin
        unique case (mode_i)
            2'b00:   width = W_MODE0;
            2'b01:   width = W_MODE1;
            2'b10:   width = W_MODE2;
            default: width = W_MODE3;
        endcase
    end

    for (genvar i = 0; i < BUS_W; i++) begin : g_lane
        assign mask_o[i] = (i < width);
    end
endmodule

// File: rtl/dbus_phase_timer.sv
module dbus_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = (count_i == '0) ? '0 : count_i - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/dbus_prst_seq.sv
module dbus_prst_seq #(
    parameter int RST_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [RST_W-1:0] cyc_i,
    output logic             prst_n_o,
    output logic             busy_o,
    output logic             booted_o
);
    typedef struct packed {
        logic             prst_n;
        logic             busy;
        logic             booted;
        logic [RST_W-1:0] cnt;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d = q;
        if (start_i && !q.busy) begin
            d.prst_n = 1'b0;
            d.busy   = 1'b1;
            d.cnt    = (cyc_i == '0) ? '0 : cyc_i - 1'b1;
        end else if (q.busy) begin
            if (q.cnt == '0) begin
                d.prst_n = 1'b1;
                d.busy   = 1'b0;
                d.booted = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{prst_n: 1'b0, busy: 1'b0, booted: 1'b0, cnt: '0};
        else        q <= d;
    end

    assign prst_n_o = q.prst_n;
    assign busy_o   = q.busy;
    assign booted_o = q.booted;
endmodule

// File: rtl/dbus_master.sv
module dbus_master
    import dbus_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int RST_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] lo_cyc_i,
    input  logic [CNT_W-1:0] hi_cyc_i,
    input  logic [RST_W-1:0] rst_cyc_i,
    input  logic             prst_req_i,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [1:0]       req_op_i,
    input  logic             req_hold_i,
    input  logic [17:0]      req_wdata_i,
    output logic             rsp_done_o,
    output logic             rsp_err_o,
    output logic [17:0]      rsp_rdata_o,
    output logic             lcd_cs_n_o,
    output logic             lcd_dc_o,
    output logic             lcd_wr_n_o,
    output logic             lcd_rd_n_o,
    output logic             lcd_rst_n_o,
    output logic [17:0]      lcd_dq_o,
    output logic             lcd_dq_oe_o,
    input  logic [17:0]      lcd_dq_i
);
    typedef struct packed {
        bus_st_e          st;
        logic             cs_n;
        logic             dc;
        logic             wr_n;
        logic             rd_n;
        logic             oe;
        logic [BUS_W-1:0] dq;
        logic             is_rd;
        logic             err;
        logic             hold;
        logic             done;
        logic [BUS_W-1:0] rdata;
    } bus_regs_t;

    bus_regs_t d, q;

    logic [BUS_W-1:0] mask;
    logic             tmr_load, tmr_exp;
    logic [CNT_W-1:0] tmr_count;
    logic             prst_start, prst_busy, booted;
    logic             ready;
    op_e              op;

    dbus_lane_mask u_mask (
        .mode_i (mode_i),
        .mask_o (mask)
    );

    dbus_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .count_i  (tmr_count),
        .expire_o (tmr_exp)
    );

    dbus_prst_seq #(.RST_W(RST_W)) u_prst (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (prst_start),
        .cyc_i    (rst_cyc_i),
        .prst_n_o (lcd_rst_n_o),
        .busy_o   (prst_busy),
        .booted_o (booted)
    );

    assign op         = op_e'(req_op_i);
    assign prst_start = prst_req_i && (q.st == ST_IDLE) && !prst_busy;
    assign ready      = (q.st == ST_IDLE) && booted && !prst_busy && !prst_req_i;
    assign tmr_load   = (q.st == ST_SETUP) || ((q.st == ST_LOW) && tmr_exp);
    assign tmr_count  = (q.st == ST_SETUP) ? lo_cyc_i : hi_cyc_i;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (prst_start) begin
                    d.hold = 1'b0;
                    d.cs_n = 1'b1;
                end else if (req_valid_i && ready) begin
                    d.st    = ST_SETUP;
                    d.cs_n  = 1'b0;
                    d.dc    = (op == OP_WR_DAT) || (op == OP_RD_DAT);
                    d.is_rd = req_op_i[1];
                    d.err   = (op == OP_RD_CMD);
                    d.oe    = !req_op_i[1];
                    d.dq    = req_op_i[1] ? '0 : (req_wdata_i & mask);
                    d.hold  = req_hold_i;
                end
            end
            ST_SETUP: begin
                d.st = ST_LOW;
                if (q.is_rd) d.rd_n = 1'b0;
                else         d.wr_n = 1'b0;
            end
            ST_LOW: begin
                if (tmr_exp) begin
                    d.st   = ST_HIGH;
                    d.wr_n = 1'b1;
                    d.rd_n = 1'b1;
                    if (q.is_rd) begin
                        d.rdata = q.err ? '0 : (lcd_dq_i & mask);
                    end
                end
            end
            default: begin
                if (tmr_exp) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.oe   = 1'b0;
                    d.dq   = '0;
                    d.cs_n = !q.hold;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cs_n: 1'b1, dc: 1'b1, wr_n: 1'b1, rd_n: 1'b1,
                   oe: 1'b0, dq: '0, is_rd: 1'b0, err: 1'b0, hold: 1'b0,
                   done: 1'b0, rdata: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready_o = ready;
    assign rsp_done_o  = q.done;
    assign rsp_err_o   = q.err;
    assign rsp_rdata_o = q.rdata;
    assign lcd_cs_n_o  = q.cs_n;
    assign lcd_dc_o    = q.dc;
    assign lcd_wr_n_o  = q.wr_n;
    assign lcd_rd_n_o  = q.rd_n;
    assign lcd_dq_o    = q.dq;
    assign lcd_dq_oe_o = q.oe;
endmodule

// File: rtl/dbus_master_chk.sv
module dbus_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  mode_i,
    input logic        req_ready_o,
    input logic        rsp_done_o,
    input logic        rsp_err_o,
    input logic [17:0] rsp_rdata_o,
    input logic        lcd_cs_n_o,
    input logic        lcd_wr_n_o,
    input logic        lcd_rd_n_o,
    input logic        lcd_rst_n_o,
    input logic [17:0] lcd_dq_o,
    input logic        lcd_dq_oe_o
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lcd_wr_n_o && !lcd_rd_n_o)); // R4

    AST_STROBE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_wr_n_o || !lcd_rd_n_o) |-> !lcd_cs_n_o); // R5

    AST_WR_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_wr_n_o |=> $stable(lcd_dq_o)); // R6

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_dq_oe_o && mode_i == 2'b00) |-> (lcd_dq_o[17:8] == 10'd0)); // R7

    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rd_n_o |-> !lcd_dq_oe_o); // R8

    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done_o && rsp_err_o) |-> (rsp_rdata_o == 18'd0)); // R9

    AST_READY_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (lcd_wr_n_o && lcd_rd_n_o)); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done_o |=> !rsp_done_o); // R11

    AST_PANEL_RESET_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n_o |-> (lcd_cs_n_o && !req_ready_o)); // R2

    AST_OE_SWITCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_dq_oe_o != $past(lcd_dq_oe_o)) |->
            (lcd_wr_n_o && lcd_rd_n_o && $past(lcd_wr_n_o) && $past(lcd_rd_n_o))); // R12
endmodule

bind dbus_master dbus_master_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .req_ready_o (req_ready_o),
    .rsp_done_o  (rsp_done_o),
    .rsp_err_o   (rsp_err_o),
    .rsp_rdata_o (rsp_rdata_o),
    .lcd_cs_n_o  (lcd_cs_n_o),
    .lcd_wr_n_o  (lcd_wr_n_o),
    .lcd_rd_n_o  (lcd_rd_n_o),
    .lcd_rst_n_o (lcd_rst_n_o),
    .lcd_dq_o    (lcd_dq_o),
    .lcd_dq_oe_o (lcd_dq_oe_o)
);

// File: tb/dbus_master_tb.sv
module dbus_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [7:0]  lo_cyc = 8'd1, hi_cyc = 8'd1;
    logic [15:0] rst_cyc = 16'd5;
    logic        prst_req = 1'b0;
    logic        valid = 1'b0;
    logic        ready;
    logic [1:0]  op = 2'b00;
    logic        hold = 1'b0;
    logic [17:0] wdata = '0;
    logic        done, err;
    logic [17:0] rdata;
    logic        cs_n, dc, wr_n, rd_n, prst_n, oe;
    logic [17:0] dq_o, dq_i;
    logic [17:0] pv = '0;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    assign dq_i = rd_n ? ~pv : pv;

    dbus_master u_dut (
        .clk (clk), .rst_n (rst_n), .mode_i (mode),
        .lo_cyc_i (lo_cyc), .hi_cyc_i (hi_cyc), .rst_cyc_i (rst_cyc),
        .prst_req_i (prst_req), .req_valid_i (valid), .req_ready_o (ready),
        .req_op_i (op), .req_hold_i (hold), .req_wdata_i (wdata),
        .rsp_done_o (done), .rsp_err_o (err), .rsp_rdata_o (rdata),
        .lcd_cs_n_o (cs_n), .lcd_dc_o (dc), .lcd_wr_n_o (wr_n),
        .lcd_rd_n_o (rd_n), .lcd_rst_n_o (prst_n), .lcd_dq_o (dq_o),
        .lcd_dq_oe_o (oe), .lcd_dq_i (dq_i)
    );

    // op[47:46] mode[45:44] lo[43:40] hi[39:36] wdata[35:18] panel[17:0]
    localparam logic [47:0] VECS [9] = '{
        {2'd0, 2'd0, 4'd1, 4'd1, 18'h3FFFF, 18'h00000},
        {2'd1, 2'd1, 4'd2, 4'd3, 18'h2A5A5, 18'h00000},
        {2'd1, 2'd2, 4'd0, 4'd0, 18'h3FFFF, 18'h00000},
        {2'd1, 2'd3, 4'd3, 4'd1, 18'h2A5A5, 18'h00000},
        {2'd2, 2'd0, 4'd2, 4'd2, 18'h00000, 18'h3C3C3},
        {2'd2, 2'd3, 4'd1, 4'd1, 18'h00000, 18'h15A5A},
        {2'd2, 2'd2, 4'd4, 4'd0, 18'h00000, 18'h3FFFF},
        {2'd3, 2'd3, 4'd1, 4'd2, 18'h00000, 18'h3FFFF},
        {2'd2, 2'd1, 4'd1, 4'd1, 18'h00000, 18'h12345}
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] lane_mask(input logic [1:0] m);
        case (m)
            2'b00:   return 18'h000FF;
            2'b01:   return 18'h0FFFF;
            2'b10:   return 18'h001FF;
            default: return 18'h3FFFF;
        endcase
    endfunction

    function automatic int eff(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    task automatic run_op(input logic [1:0] o, input logic [1:0] m,
                          input int lo, input int hi, input logic h,
                          input logic [17:0] wd, input logic [17:0] p);
        int  n = 0, lows = 0, first_low = -1;
        bit  dc_ok = 1, oe_ok = 1, dq_ok = 1, other_ok = 1, contig = 1, cs_ok = 1;
        logic exp_dc   = (o == 2'd1) || (o == 2'd2);
        logic is_rd    = o[1];
        logic [17:0] exp_dq = wd & lane_mask(m);
        @(negedge clk);
        op = o; mode = m; lo_cyc = 8'(lo); hi_cyc = 8'(hi); hold = h;
        wdata = wd; pv = p; valid = 1'b1;
        check(ready === 1'b1, "R11 ready before request", 32'(ready), 1);
        @(negedge clk);
        valid = 1'b0;
        while (done !== 1'b1 && n < 300) begin
            logic act_n = is_rd ? rd_n : wr_n;
            logic oth_n = is_rd ? wr_n : rd_n;
            if (dc !== exp_dc) dc_ok = 0;
            if (cs_n !== 1'b0) cs_ok = 0;
            if (oe !== !is_rd) oe_ok = 0;
            if (!is_rd && dq_o !== exp_dq) dq_ok = 0;
            if (oth_n !== 1'b1) other_ok = 0;
            if (act_n === 1'b0) begin
                if (first_low < 0) first_low = n;
                else if (n != first_low + lows) contig = 0;
                lows++;
            end
            n++;
            @(negedge clk);
        end
        check(first_low == 1, "R5 cs falls one clock before strobe", 32'(first_low), 1);
        check(lows == eff(lo) && contig, "R4 strobe low length", 32'(lows), 32'(eff(lo)));
        check(n - 1 - lows == eff(hi), "R4 strobe high length", 32'(n - 1 - lows), 32'(eff(hi)));
        check(other_ok, "R4 other strobe idle", 32'(other_ok), 1);
        check(dc_ok, "R3 data/command level", 32'(dc), 32'(exp_dc));
        check(cs_ok, "R5 cs low during cycle", 32'(cs_ok), 1);
        check(cs_n === !h, "R5 cs at done", 32'(cs_n), 32'(!h));
        if (is_rd) begin
            logic [17:0] exp_rd = (o == 2'd3) ? 18'h0 : (p & lane_mask(m));
            check(oe_ok, "R8 bus released during read", 32'(oe_ok), 1);
            check(rdata === exp_rd, (o == 2'd3) ? "R9 read data" : "R8 R7 read data",
                  32'(rdata), 32'(exp_rd));
            check(err === (o == 2'd3), (o == 2'd3) ? "R9 error flag" : "R8 error flag",
                  32'(err), 32'(o == 2'd3));
        end else begin
            check(oe_ok, "R6 output enable during write", 32'(oe_ok), 1);
            check(dq_ok, "R6 R7 write data lanes", 32'(dq_o), 32'(exp_dq));
        end
        @(negedge clk);
        check(done === 1'b0, "R11 done single clock", 32'(done), 0);
    endtask

    task automatic panel_reset(input int cyc);
        int lowcnt = 0;
        @(negedge clk);
        rst_cyc = 16'(cyc); prst_req = 1'b1;
        @(negedge clk);
        prst_req = 1'b0;
        while (prst_n === 1'b0 && lowcnt < 100) begin
            if (ready !== 1'b0) check(0, "R2 ready during panel reset", 32'(ready), 0);
            lowcnt++;
            @(negedge clk);
        end
        check(lowcnt == eff(cyc), "R2 panel reset length", 32'(lowcnt), 32'(eff(cyc)));
        check(ready === 1'b1, "R2 ready after panel reset", 32'(ready), 1);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n === 1'b1 && wr_n === 1'b1 && rd_n === 1'b1, "R1 strobes and select idle",
              {29'd0, cs_n, wr_n, rd_n}, 32'h7);
        check(oe === 1'b0, "R1 output enable", 32'(oe), 0);
        check(prst_n === 1'b0, "R1 panel reset held", 32'(prst_n), 0);
        valid = 1'b1;
        repeat (3) @(negedge clk);
        check(ready === 1'b0 && cs_n === 1'b1, "R2 no access before panel reset",
              {30'd0, ready, cs_n}, 32'h1);
        valid = 1'b0;
        panel_reset(5);
        panel_reset(0);

        for (int i = 0; i < 9; i++) begin
            logic [47:0] v = VECS[i];
            run_op(v[47:46], v[45:44], int'(v[43:40]), int'(v[39:36]), 1'b0,
                   v[35:18], v[17:0]);
        end

        // R10: held command then its parameter
        run_op(2'd0, 2'd0, 1, 1, 1'b1, 18'h0002C, 18'h0);
        repeat (3) @(negedge clk);
        check(cs_n === 1'b0, "R10 cs held across idle", 32'(cs_n), 0);
        run_op(2'd1, 2'd1, 2, 1, 1'b0, 18'h1F00F, 18'h0);
        check(cs_n === 1'b1, "R10 cs released after parameter", 32'(cs_n), 1);

        // R4 larger counts
        run_op(2'd1, 2'd3, 7, 5, 1'b0, 18'h3FFFF, 18'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule